// File: doc/BRIEF.md
# Instruction Cycle Pacing Timer

This block holds back the fetch of the next emulated instruction until the current one has used up its exact number of bus cycles. The tick enable marks each 1 µs bus cycle. When the controller begins an instruction, it reports that instruction's base length in ticks. The block clears its tick counter and loads a compare target with that length. If an indexed access crosses a page boundary while the instruction runs, the controller raises a bump, and the target grows by one tick.

When the counter reaches the target, the block opens a service window of one clock. The controller handles interrupts and peripherals in that window. After the window closes, the ready-for-fetch output rises again. A length outside 2 to 7 is clamped into that range and sets a sticky flag. A bump that arrives when no instruction is running is refused and sets a separate sticky flag. A running total of consumed ticks lets a testbench compare cycle counts across a whole program.

Top module: `instr_pacer`

## Requirements
- R1: While reset is asserted, fetch_ready_o is 0, total_o is 0 and both error flags are 0. In the first cycle after reset is released, fetch_ready_o is 1 and svc_win_o is 0.
- R2: A start_i accepted while fetch_ready_o is 1 drops fetch_ready_o at the next clock edge.
- R3: With tick_en_i held at 1, an instruction of legal length L (2..7) and no bump raises svc_win_o exactly L clock cycles after the start edge.
- R4: A cycle with tick_en_i at 0 during an instruction adds no progress. Each such cycle delays the service window by one cycle.
- R5: A bump_i during a running instruction extends it by exactly one tick. This also holds when the bump falls in the same cycle as the tick that would otherwise have ended the instruction.
- R6: A bump_i while no instruction is running does not change the timing. It sets the sticky bump_err_o, which stays at 1 until reset.
- R7: A length below 2 is run as 2 ticks and a length above 7 is run as 7 ticks. Either case sets the sticky len_err_o, which stays at 1 until reset.
- R8: total_o increases by one for every tick consumed inside an instruction. It keeps its value across instruction starts and between instructions.
- R9: A start_i while fetch_ready_o is 0 is ignored. The running instruction keeps its length and total_o is unaffected.
- R10: svc_win_o is 1 for exactly one cycle per instruction, and fetch_ready_o is 1 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en_i | input | 1 | One bus-cycle tick |
| start_i | input | 1 | Begin an instruction |
| len_i | input | LEN_W | Base length of the instruction, in ticks |
| bump_i | input | 1 | Add one tick to the running instruction (page crossing) |
| fetch_ready_o | output | 1 | The next opcode fetch may proceed |
| svc_win_o | output | 1 | Interrupt and peripheral service window |
| total_o | output | TOTAL_W | Accumulated ticks consumed |
| bump_err_o | output | 1 | Sticky: a bump was refused |
| len_err_o | output | 1 | Sticky: a length was clamped |

## Verification
Two functions can collide in one cycle: the tick that would complete the instruction and a page-crossing bump. The bench raises the bump in the final tick cycle of an instruction and expects the service window one cycle later than the base length gives. It also pauses the tick enable and issues a stray start in the middle of an instruction, then judges only the service-window cycle and the tick total.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_RUN   = 2'd1,
    ST_SVC   = 2'd2
  } pace_state_t;

  // clamp a requested length into the legal window
  function automatic int clamp_len(int req, int lo, int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // compare target after an optional one-tick extension, saturating at cap
  function automatic int grow_target(int cur, bit ext, int cap);
    if (ext && cur < cap) return cur + 1;
    return cur;
  endfunction

endpackage

// File: rtl/pacer_len_sat.sv
module pacer_len_sat #(
  parameter int LEN_W   = 4,
  parameter int CNT_W   = 4,
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 7
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] len_o,
  output logic             bad_o
);
  int req;

  always_comb begin
    req   = int'(len_i);
    len_o = CNT_W'(pacer_pkg::clamp_len(req, MIN_LEN, MAX_LEN));
    bad_o = (req < MIN_LEN) || (req > MAX_LEN);
  end

  always_comb begin
    AST_LEN_IN_RANGE: assert (int'(len_o) >= MIN_LEN && int'(len_o) <= MAX_LEN) else $error("clamped length out of range"); // R7
  end
endmodule

// File: rtl/pacer_tick_cnt.sv
module pacer_tick_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             bump_i,
  output logic             match_o
);
  localparam int CAP = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic [CNT_W-1:0] cnt_nxt, cmp_eff;

  always_comb begin
    cmp_eff = CNT_W'(pacer_pkg::grow_target(int'(cmp_q), bump_i, CAP));
    cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, tick_i};
    match_o = run_i && tick_i && (cnt_nxt == cmp_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      cmp_q <= load_i;
    end else if (run_i) begin
      cnt_q <= cnt_nxt;
      cmp_q <= cmp_eff;
    end
  end

  AST_CNT_NOT_PAST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= cmp_q)) else $error("tick count passed target"); // R3
  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i && !clear_i) |=> $stable(cnt_q)) else $error("count moved without tick"); // R4
  AST_BUMP_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && bump_i && !clear_i && cmp_q != CNT_W'(CAP)) |=> (cmp_q == $past(cmp_q) + 1'b1)) else $error("bump lost"); // R5
endmodule

// File: rtl/pacer_total.sv
module pacer_total #(
  parameter int TOTAL_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  output logic [TOTAL_W-1:0] total_o
);
  logic [TOTAL_W-1:0] total_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     total_q <= '0;
    else if (inc_i) total_q <= total_q + 1'b1;
  end

  assign total_o = total_q;

  AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(total_q)) else $error("total moved without tick"); // R8
endmodule

// File: rtl/instr_pacer.sv
module instr_pacer #(
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 7,
  parameter int TOTAL_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en_i,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               bump_i,
  output logic               fetch_ready_o,
  output logic               svc_win_o,
  output logic [TOTAL_W-1:0] total_o,
  output logic               bump_err_o,
  output logic               len_err_o
);
  import pacer_pkg::*;

  localparam int CNT_W = $clog2(2 * MAX_LEN + 1);

  pace_state_t      st_q, st_d;
  logic [CNT_W-1:0] load_len;
  logic             len_bad, match;
  logic             bump_err_q, len_err_q;

  // named internal events
  logic running, start_acc, bump_acc, bump_rej, tick_now;
  assign running   = (st_q == ST_RUN);
  assign start_acc = start_i && (st_q == ST_READY);
  assign bump_acc  = bump_i && running;
  assign bump_rej  = bump_i && !running;
  assign tick_now  = running && tick_en_i;

  pacer_len_sat #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_len (
    .len_i (len_i),
    .len_o (load_len),
    .bad_o (len_bad)
  );

  pacer_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc),
    .load_i  (load_len),
    .run_i   (running),
    .tick_i  (tick_en_i),
    .bump_i  (bump_acc),
    .match_o (match)
  );

  pacer_total #(.TOTAL_W(TOTAL_W)) u_tot (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (tick_now),
    .total_o (total_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_READY: if (start_acc) st_d = ST_RUN;
      ST_RUN:   if (match)     st_d = ST_SVC;
      ST_SVC:                  st_d = ST_READY;
      default:                 st_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_READY;
      bump_err_q <= 1'b0;
      len_err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (bump_rej)             bump_err_q <= 1'b1;
      if (start_acc && len_bad) len_err_q  <= 1'b1;
    end
  end

  assign fetch_ready_o = rst_n && (st_q == ST_READY);
  assign svc_win_o     = (st_q == ST_SVC);
  assign bump_err_o    = bump_err_q;
  assign len_err_o     = len_err_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && fetch_ready_o) |=> !fetch_ready_o) else $error("ready held after start"); // R2
  AST_SVC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_win_o |=> (!svc_win_o && fetch_ready_o)) else $error("service window not one cycle"); // R10
  AST_BUMP_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bump_err_o |=> bump_err_o) else $error("bump error cleared"); // R6
  AST_LEN_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_o |=> len_err_o) else $error("length error cleared"); // R7
  AST_SVC_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_win_o) |-> $past(running)) else $error("window without instruction"); // R10
endmodule

// File: tb/tb_instr_pacer.sv
`timescale 1ns/1ps
module tb_instr_pacer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en_i = 1'b1;
  logic        start_i = 1'b0;
  logic [3:0]  len_i = '0;
  logic        bump_i = 1'b0;
  logic        fetch_ready_o, svc_win_o, bump_err_o, len_err_o;
  logic [31:0] total_o;

  int checks = 0;
  int fails  = 0;
  int exp_total = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  instr_pacer dut (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .start_i(start_i),
    .len_i(len_i), .bump_i(bump_i), .fetch_ready_o(fetch_ready_o),
    .svc_win_o(svc_win_o), .total_o(total_o), .bump_err_o(bump_err_o),
    .len_err_o(len_err_o)
  );

  // length, bump cycle index (99 = none)
  localparam int NV = 8;
  localparam int VLEN [NV] = '{2, 7, 3, 5, 4, 6, 2, 7};
  localparam int VBMP [NV] = '{99, 99, 0, 4, 2, 99, 1, 6};

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int legal_len(int l);
    return (l < 2) ? 2 : ((l > 7) ? 7 : l);
  endfunction

  // runs one instruction; returns cycles from start edge to service window
  task automatic run_instr(input int len, input int bmp, input int pz_at, input int pz_n,
                           input int ign_at, input string tag);
    int n;
    int ticks;
    int expc;
    ticks = legal_len(len) + ((bmp < legal_len(len)) ? 1 : 0);
    expc  = ticks + pz_n;
    chk(fetch_ready_o === 1'b1, {tag, " R2 ready before start"}, int'(fetch_ready_o), 1);
    start_i = 1'b1; len_i = 4'(len);
    @(negedge clk);
    start_i = 1'b0;
    chk(fetch_ready_o === 1'b0, {tag, " R2 ready drops"}, int'(fetch_ready_o), 0);
    n = 0;
    while (n < 40) begin
      bump_i    = (n == bmp);
      tick_en_i = !(n >= pz_at && n < pz_at + pz_n);
      start_i   = (n == ign_at);
      len_i     = (n == ign_at) ? 4'd7 : len_i;
      @(negedge clk);
      n++;
      if (svc_win_o) break;
    end
    bump_i = 1'b0; tick_en_i = 1'b1; start_i = 1'b0;
    exp_total += ticks;
    chk(n == expc, {tag, " R3 window cycle"}, n, expc);
    chk(total_o == 32'(exp_total), {tag, " R8 total"}, int'(total_o), exp_total);
    @(negedge clk);
    chk(svc_win_o === 1'b0 && fetch_ready_o === 1'b1, {tag, " R10 window one cycle then ready"},
        int'({svc_win_o, fetch_ready_o}), 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        checks++;
        $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 20000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fetch_ready_o === 1'b0, "R1 ready in reset", int'(fetch_ready_o), 0);
    chk(total_o == 0 && !bump_err_o && !len_err_o, "R1 cleared in reset", int'(total_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_ready_o === 1'b1 && svc_win_o === 1'b0, "R1 ready after reset", int'(fetch_ready_o), 1);

    // table of vectors
    for (int i = 0; i < NV; i++) run_instr(VLEN[i], VBMP[i], 99, 0, 99, $sformatf("vec%0d R5", i));

    // R4 pause of three ticks
    run_instr(4, 99, 1, 3, 99, "R4 pause");

    // R9 stray start mid-instruction
    run_instr(3, 99, 99, 0, 1, "R9 stray start");

    // R6 bump while idle
    chk(bump_err_o === 1'b0, "R6 no error yet", int'(bump_err_o), 0);
    bump_i = 1'b1;
    @(negedge clk);
    bump_i = 1'b0;
    chk(bump_err_o === 1'b1, "R6 bump refused", int'(bump_err_o), 1);
    chk(fetch_ready_o === 1'b1 && total_o == 32'(exp_total), "R6 no timing effect", int'(total_o), exp_total);
    run_instr(3, 99, 99, 0, 99, "R6 next instr");
    chk(bump_err_o === 1'b1, "R6 sticky", int'(bump_err_o), 1);

    // R7 clamping
    chk(len_err_o === 1'b0, "R7 no error yet", int'(len_err_o), 0);
    run_instr(0, 99, 99, 0, 99, "R7 low clamp");
    chk(len_err_o === 1'b1, "R7 flag low", int'(len_err_o), 1);
    run_instr(15, 99, 99, 0, 99, "R7 high clamp");
    run_instr(2, 99, 99, 0, 99, "R7 legal after");
    chk(len_err_o === 1'b1, "R7 sticky", int'(len_err_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule